// File: doc/BRIEF.md
# Manchester Word Encoder with Sync Header

This block turns a 16-bit word, supplied one bit at a time by an outside shift source, into one self-clocked serial frame for a two-wire bipolar bus. A frame lasts 20 bit times. It opens with a 3-bit-time sync header that is not Manchester coded: one polarity for 1.5 bit times, then the other polarity for 1.5 bit times. The order of the two halves marks the frame as a command frame or a data frame. Sixteen Manchester II data bits follow, most significant first. The frame closes with an odd parity bit, also Manchester coded.

The block runs from one clock at twice the bit rate, so each clock cycle carries one half-bit. It puts out a shift strobe that toggles on every clock, which gives one strobe period per bit time. A send window output tells the data source when to present serial bits. The line outputs are a pair of active-low signals, one for each bus sense. An active-low inhibit input forces both line outputs to their inactive high level without disturbing the frame sequence. If enable is held high, frames follow one another with no gap. A synchronous master reset aborts a frame at any point.

Top module: `manch_word_enc`

## Requirements
- R1: While `rst` is high and on the cycle after it, `strobe` is 0, `one_n` and `zero_n` are both 1, and `send_win` is 0.
- R2: `strobe` toggles on every clock edge that is not in reset. Half-bit slot k of a frame (k = 0..39) has `strobe` equal to k mod 2, so each bit time is one strobe low followed by one strobe high.
- R3: A frame starts only when `enable` is high at a clock edge where `strobe` was high (the falling strobe edge). Slot 0 is shown on the outputs right after that edge. `enable` that is high only at an edge where `strobe` was low starts nothing.
- R4: `sync_sel` is sampled at the edge that starts the frame. Its later changes do not affect that frame. A command frame (1) drives the line positive in slots 0..2 and negative in slots 3..5. A data frame (0) does the reverse. Positive means `one_n`=0 and `zero_n`=1. Negative means `one_n`=1 and `zero_n`=0.
- R5: `send_win` is high in slots 4..35 and low in all other slots. `ser_in` is captured at the end of each odd slot in that window, which gives 16 bits, first captured first.
- R6: Data bit i (counting from the most significant, i = 0..15) occupies slots 6+2i and 7+2i. A 1 is sent positive then negative, and a 0 negative then positive.
- R7: Slots 38 and 39 carry an odd parity bit in the same Manchester code, so the data bits and the parity bit together contain an odd number of ones.
- R8: If `enable` is high at the end of slot 39, the next frame's slot 0 follows at once with no gap, using the `sync_sel` value present at that edge.
- R9: If `enable` is low at the end of slot 39, the block goes idle. `one_n` and `zero_n` are 1 and `send_win` is 0 until a new start.
- R10: `inh_n` low at a clock edge forces `one_n` and `zero_n` high for the next cycle. The slot count and the captured data are unaffected, so the frame resumes in its proper slot.
- R11: `rst` high at a clock edge during a frame aborts the frame at that edge, and the outputs return to the idle values of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Send clock, two cycles per bit time |
| rst | input | 1 | Synchronous active-high master reset, aborts a frame |
| enable | input | 1 | Frame request, sampled at falling strobe edges |
| sync_sel | input | 1 | Header type: 1 command, 0 data |
| ser_in | input | 1 | NRZ serial data from the external shift source |
| inh_n | input | 1 | Active-low output inhibit |
| strobe | output | 1 | Shift strobe, one period per bit time |
| send_win | output | 1 | High while the source must supply serial bits |
| one_n | output | 1 | Active-low positive-sense line output |
| zero_n | output | 1 | Active-low negative-sense line output |

## Verification
Single frames are sent with words that separate the cases that matter. Alternating, all-zero and all-one patterns expose a swapped half-bit order or a stuck level. Patterns with only the end bits set expose shift-order and off-by-one slot errors. Words with odd and even numbers of ones exercise both parity values. Both header types appear across the set. A back-to-back pair with `sync_sel` flipped mid-frame tells a gapless restart apart from a one-slot bubble, and tells sampling at the start edge apart from sampling later. Directed runs then cover inhibit in the middle of a frame, an enable pulse on the wrong strobe phase, and reset in the middle of a frame.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  typedef struct packed {
    logic one_n;
    logic zero_n;
  } line_t;

  localparam line_t LINE_IDLE = '{one_n: 1'b1, zero_n: 1'b1};

  // positive line level: one-sense active (low), zero-sense inactive
  function automatic line_t drive_level(input logic pos);
    drive_level = '{one_n: ~pos, zero_n: pos};
  endfunction

  // Manchester II half-bit: value in first half, complement in second
  function automatic logic manch_half(input logic val, input logic second);
    manch_half = val ^ second;
  endfunction

endpackage

// File: rtl/mwe_seq.sv
module mwe_seq #(
  parameter int LAST   = 39,
  parameter int WIN_LO = 4,
  parameter int WIN_HI = 35,
  parameter int SW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          sync_sel,
  output logic          ph_q,
  output logic          act_q,
  output logic          act_n,
  output logic [SW-1:0] s_n,
  output logic          cmd_n,
  output logic          start,
  output logic          cap
);

  logic [SW-1:0] s_q;
  logic          cmd_q;
  logic          last;

  assign last  = act_q && (s_q == SW'(LAST));
  assign start = enable && ph_q && (!act_q || last);
  assign cap   = act_q && s_q[0] && (s_q >= SW'(WIN_LO)) && (s_q <= SW'(WIN_HI));

  always_comb begin
    act_n = start || (act_q && !last);
    if (start)                s_n = '0;
    else if (act_q && !last)  s_n = s_q + SW'(1);
    else                      s_n = '0;
    cmd_n = start ? sync_sel : cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 1'b0;
      act_q <= 1'b0;
      s_q   <= '0;
      cmd_q <= 1'b0;
    end else begin
      ph_q  <= ~ph_q;
      act_q <= act_n;
      s_q   <= s_n;
      cmd_q <= cmd_n;
    end
  end

  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(ph_q)); // R3

  AST_WRAP_STOP: assert property (@(posedge clk) disable iff (rst)
    (last && !enable) |=> !act_q); // R9

  AST_RESET_ABORT: assert property (@(posedge clk)
    rst |=> (!act_q && !ph_q)); // R11

endmodule

// File: rtl/mwe_bitpath.sv
module mwe_bitpath (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cap,
  input  logic ser_in,
  output logic bit_n,
  output logic par_n
);

  logic bit_q;
  logic par_q;

  always_comb begin
    bit_n = cap ? ser_in : bit_q;
    if (start)    par_n = 1'b1;           // odd parity seed
    else if (cap) par_n = par_q ^ ser_in;
    else          par_n = par_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      par_q <= 1'b1;
    end else begin
      bit_q <= bit_n;
      par_q <= par_n;
    end
  end

endmodule

// File: rtl/mwe_line.sv
module mwe_line
  import mwe_pkg::*;
#(
  parameter int SW         = 6,
  parameter int SYNC_HALF  = 3,
  parameter int SYNC_SLOTS = 6,
  parameter int WIN_LO     = 4,
  parameter int WIN_HI     = 35,
  parameter int PAR_SLOT   = 38
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inh_n,
  input  logic          act_n,
  input  logic [SW-1:0] s_n,
  input  logic          cmd_n,
  input  logic          bit_n,
  input  logic          par_n,
  output logic          one_n,
  output logic          zero_n,
  output logic          send_win
);

  logic  pos;
  line_t lvl;
  logic  win;

  always_comb begin
    if (s_n < SW'(SYNC_SLOTS))
      pos = cmd_n ? (s_n < SW'(SYNC_HALF)) : (s_n >= SW'(SYNC_HALF));
    else if (s_n < SW'(PAR_SLOT))
      pos = manch_half(bit_n, s_n[0]);
    else
      pos = manch_half(par_n, s_n[0]);
    lvl = (act_n && inh_n) ? drive_level(pos) : LINE_IDLE;
    win = act_n && (s_n >= SW'(WIN_LO)) && (s_n <= SW'(WIN_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      one_n    <= 1'b1;
      zero_n   <= 1'b1;
      send_win <= 1'b0;
    end else begin
      one_n    <= lvl.one_n;
      zero_n   <= lvl.zero_n;
      send_win <= win;
    end
  end

  AST_INHIBIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    !inh_n |=> (one_n && zero_n)); // R10

  AST_LINES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!one_n && !zero_n)); // R6

endmodule

// File: rtl/manch_word_enc.sv
module manch_word_enc #(
  parameter int DATA_W    = 16,
  parameter int SYNC_HALF = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sync_sel,
  input  logic ser_in,
  input  logic inh_n,
  output logic strobe,
  output logic send_win,
  output logic one_n,
  output logic zero_n
);

  localparam int SYNC_SLOTS = 2 * SYNC_HALF;
  localparam int WIN_LO     = SYNC_SLOTS - 2;
  localparam int WIN_HI     = WIN_LO + 2 * DATA_W - 1;
  localparam int PAR_SLOT   = SYNC_SLOTS + 2 * DATA_W;
  localparam int LAST       = PAR_SLOT + 1;
  localparam int SW         = $clog2(LAST + 1);

  logic          ph_q, act_q, act_n, cmd_n, start, cap;
  logic [SW-1:0] s_n;
  logic          bit_n, par_n;

  mwe_seq #(.LAST(LAST), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .SW(SW)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .sync_sel(sync_sel),
    .ph_q(ph_q), .act_q(act_q), .act_n(act_n), .s_n(s_n),
    .cmd_n(cmd_n), .start(start), .cap(cap)
  );

  mwe_bitpath u_bits (
    .clk(clk), .rst(rst), .start(start), .cap(cap), .ser_in(ser_in),
    .bit_n(bit_n), .par_n(par_n)
  );

  mwe_line #(
    .SW(SW), .SYNC_HALF(SYNC_HALF), .SYNC_SLOTS(SYNC_SLOTS),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .PAR_SLOT(PAR_SLOT)
  ) u_line (
    .clk(clk), .rst(rst), .inh_n(inh_n), .act_n(act_n), .s_n(s_n),
    .cmd_n(cmd_n), .bit_n(bit_n), .par_n(par_n),
    .one_n(one_n), .zero_n(zero_n), .send_win(send_win)
  );

  assign strobe = ph_q;

  AST_WIN_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    send_win |-> act_q); // R5

  AST_STROBE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (strobe != $past(strobe))); // R2

endmodule

// File: tb/test_manch_word_enc.sv
module test_manch_word_enc;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, sync_sel = 1'b0, ser_in = 1'b0, inh_n = 1'b1;
  logic strobe, send_win, one_n, zero_n;
  int   total = 0, fails = 0;

  always #2 clk = ~clk;   // 250 MHz

  manch_word_enc i_manch_word_enc (
    .clk(clk), .rst(rst), .enable(enable), .sync_sel(sync_sel),
    .ser_in(ser_in), .inh_n(inh_n), .strobe(strobe), .send_win(send_win),
    .one_n(one_n), .zero_n(zero_n)
  );

  // {command, data}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'hA5C3}, {1'b0, 16'h0000}, {1'b1, 16'hFFFF},
    {1'b0, 16'h8001}, {1'b1, 16'h1234}, {1'b0, 16'h7FFE}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_pos(input logic cmd, input logic [15:0] d, input int k);
    if (k < 6)       return cmd ? (k < 3) : (k >= 3);
    else if (k < 38) return d[15 - (k - 6) / 2] ^ k[0];
    else             return (~^d) ^ k[0];
  endfunction

  task automatic check_idle(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check(one_n && zero_n && !send_win, req, {one_n, zero_n, send_win}, 3'b110);
    end
  endtask

  task automatic begin_frame(input logic cmd);
    @(negedge clk);
    while (strobe !== 1'b1) @(negedge clk);
    enable = 1'b1;
    sync_sel = cmd;
  endtask

  task automatic run_frame(input logic cmd, input logic [15:0] d, input logic next_en,
                           input logic next_sel, input int inh_slot);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin enable = next_en; sync_sel = next_sel; end
      check(strobe == k[0], "R2", strobe, k[0]);
      check(send_win == (k >= 4 && k <= 35), "R5", send_win, (k >= 4 && k <= 35));
      if (inh_slot >= 0 && k == inh_slot + 1) begin
        check(one_n && zero_n, "R10", {one_n, zero_n}, 2'b11);
        inh_n = 1'b1;
      end else begin
        logic p;
        p = exp_pos(cmd, d, k);
        check({one_n, zero_n} == {~p, p}, (k < 6) ? "R4" : (k < 38) ? "R6" : "R7",
              {one_n, zero_n}, {~p, p});
      end
      if (k == inh_slot) inh_n = 1'b0;
      ser_in = (k >= 4 && k <= 35) ? d[15 - (k - 4) / 2] : 1'b0;
    end
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!strobe && one_n && zero_n && !send_win, "R1",
          {strobe, one_n, zero_n, send_win}, 4'b0110);
    rst = 1'b0;
    check_idle(4, "R9");

    // table of single frames, one with inhibit mid-frame
    for (int v = 0; v < 6; v++) begin
      begin_frame(VEC[v][16]);
      run_frame(VEC[v][16], VEC[v][15:0], 1'b0, 1'b0, (v == 2) ? 20 : -1);
      check_idle(3, "R9");
    end

    // R3: enable only at a strobe-rising edge starts nothing
    @(negedge clk);
    while (strobe !== 1'b0) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
    check_idle(6, "R3");

    // R8 / R4: back to back, sync_sel flipped during first frame
    begin_frame(1'b1);
    run_frame(1'b1, 16'hC0DE, 1'b1, 1'b0, -1);
    run_frame(1'b0, 16'h0F0F, 1'b0, 1'b1, -1);
    check_idle(2, "R8");

    // R11: reset aborts a frame in progress
    begin_frame(1'b0);
    for (int k = 0; k < 10; k++) @(negedge clk);
    enable = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!strobe && one_n && zero_n && !send_win, "R11",
          {strobe, one_n, zero_n, send_win}, 4'b0110);
    rst = 1'b0;
    check_idle(6, "R11");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule